// File: doc/BRIEF.md
# Presettable synchronous binary counter

A four-bit up-counter that moves only on the rising clock edge and wraps from fifteen back to zero. On each edge it does one of four things, in strict priority. An active-low clear forces zero. An active-low load copies the parallel data word. When both count enables are high it increments. Otherwise it holds.

A carry flag is decoded without a register from the counter value and one of the two enables. That enable is the carry-qualifying one. This lets stages be chained into wider counters with no glue logic. Each stage's carry feeds the next stage's carry-qualifying enable. The clear, load and plain count enable are shared by all stages.

There is no asynchronous reset. A user applies a clear edge before relying on the count.

Top module: `preset_bin_counter`

## Requirements
- R1: When clear_n is 0 at a rising edge, count becomes 0 whatever load_n, cnt_en and carry_en are.
- R2: A low clear_n that returns high before the next rising edge leaves count unchanged; count never changes between edges.
- R3: With clear_n 1 and load_n 0 at a rising edge, count takes din, whatever the levels of cnt_en and carry_en.
- R4: With clear_n and load_n both 1 and cnt_en and carry_en both 1 at a rising edge, count increases by one.
- R5: With clear_n and load_n both 1 and either cnt_en or carry_en at 0, count holds its value.
- R6: An increment from 15 (1111) gives 0 (0000).
- R7: carry_out is 1 exactly when carry_en is 1 and count is 15. It follows carry_en within the same cycle, also while the counter holds, and cnt_en has no effect on it.
- R8: Two stages, with the lower stage's carry_out driving the upper stage's carry_en and all other controls shared, form a modulo-256 counter. The upper stage holds bits 7..4. The upper carry_out is 1 exactly at 255 with the outer carry_en 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable that does not affect the carry |
| carry_en | input | 1 | Count enable that also qualifies carry_out |
| din | input | WIDTH (4) | Parallel load data |
| count | output | WIDTH (4) | Counter value |
| carry_out | output | 1 | High when carry_en is 1 and count is all ones |

## Verification
Clear and load compete in the same edge, as do load and count. The bench provokes this with random control levels in which clear_n and load_n are both low, or load_n is low with both enables high. It judges each edge against a priority model: clear, then load, then count, then hold. A second contest is between the carry and a hold. Here the counter sits at 15 with cnt_en low while carry_en toggles, and the carry must track carry_en with count unchanged. The same model, widened to eight bits, judges the two-stage chain through its wrap at 255.

// File: rtl/preset_bin_counter.sv
module preset_bin_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic advance;
  assign advance = cnt_en & carry_en;

  always_ff @(posedge clk) begin
    if (!clear_n)
      count <= '0;
    else if (!load_n)
      count <= din;
    else if (advance)
      count <= count + WIDTH'(1);
  end

  assign carry_out = carry_en & (count == ALL_ONES);
endmodule

// File: rtl/preset_bin_counter_chk.sv
module preset_bin_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             carry_en,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (!clear_n) armed <= 1'b1;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> count == '0);
  p_load_copy_r3: assert property (@(posedge clk) disable iff (!armed)
    clear_n && !load_n |=> count == $past(din));
  p_step_up_r4: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && cnt_en && carry_en |=> count == WIDTH'($past(count) + WIDTH'(1)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && !(cnt_en && carry_en) |=> $stable(count));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && cnt_en && carry_out |=> count == '0);
  p_carry_gate_r7: assert property (@(posedge clk) disable iff (!armed)
    !carry_en |-> !carry_out);
endmodule

bind preset_bin_counter preset_bin_counter_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/preset_bin_counter_tb.sv
module preset_bin_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic clear_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
  logic [3:0] din_lo = '0, din_hi = '0;
  logic [3:0] count_lo, count_hi;
  logic carry_lo, carry_hi;

  preset_bin_counter #(.WIDTH(4)) dut_i (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din_lo), .count(count_lo), .carry_out(carry_lo));

  preset_bin_counter #(.WIDTH(4)) dut_hi_i (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_lo), .din(din_hi), .count(count_hi), .carry_out(carry_hi));

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [7:0] model = '0;

  function automatic logic [7:0] next_model(logic [7:0] cur, logic c_n, logic l_n,
                                            logic p, logic t, logic [7:0] d);
    if (!c_n) return 8'h00;
    if (!l_n) return d;
    if (p && t) return cur + 8'h01;
    return cur;
  endfunction

  function automatic logic carry_model(logic [7:0] cur, logic t, bit wide);
    return t && (wide ? (cur == 8'hFF) : (cur[3:0] == 4'hF));
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(logic c_n, logic l_n, logic p, logic t, logic [7:0] d, string req);
    @(negedge clk);
    clear_n = c_n; load_n = l_n; cnt_en = p; carry_en = t;
    din_lo = d[3:0]; din_hi = d[7:4];
    #1;
    check({req, "/R7 carry lo"}, {7'd0, carry_lo}, {7'd0, carry_model(model, t, 0)});
    check({req, "/R8 carry hi"}, {7'd0, carry_hi}, {7'd0, carry_model(model, t, 1)});
    @(posedge clk);
    model = next_model(model, c_n, l_n, p, t, d);
    #1;
    check({req, " low stage"}, {4'h0, count_lo}, {4'h0, model[3:0]});
    check({req, "/R8 chain"}, {count_hi, count_lo}, model);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd12345);
    @(negedge clk);
    clear_n = 0; load_n = 0; cnt_en = 1; carry_en = 1; din_lo = 4'h9; din_hi = 4'h6;
    @(posedge clk);
    model = 8'h00;
    #1;
    check("R1 reset state", {count_hi, count_lo}, 8'h00);

    cycle(0, 0, 1, 1, 8'hA5, "R1 clear beats load");
    cycle(1, 0, 0, 0, 8'h3C, "R3 load enables low");
    cycle(0, 1, 1, 1, 8'h00, "R1 clear beats count");
    cycle(1, 0, 1, 1, 8'hC7, "R3 load beats count");
    cycle(1, 1, 0, 1, 8'h00, "R5 hold cnt_en low");
    cycle(1, 1, 1, 0, 8'h00, "R5 hold carry_en low");
    cycle(1, 1, 1, 1, 8'h00, "R4 increment");

    @(negedge clk);
    clear_n = 0;
    #2;
    check("R2 no change between edges", {count_hi, count_lo}, model);
    clear_n = 1; cnt_en = 0; carry_en = 0;
    @(posedge clk);
    #1;
    check("R2 short clear pulse ignored", {count_hi, count_lo}, model);

    cycle(1, 0, 0, 0, 8'h2F, "R3 load 15");
    cycle(1, 1, 0, 1, 8'h00, "R7 carry while hold");
    cycle(1, 1, 0, 0, 8'h00, "R7 carry drops with carry_en");
    cycle(1, 1, 1, 1, 8'h00, "R6 wrap low stage");

    cycle(1, 0, 0, 0, 8'hFD, "R3 load FD");
    for (int i = 0; i < 260; i++) cycle(1, 1, 1, 1, 8'h00, "R8 modulo-256 run");

    for (int i = 0; i < 3000; i++) begin
      logic c_n, l_n, p, t;
      c_n = ($urandom_range(99) >= 4);
      l_n = ($urandom_range(99) >= 10);
      p = ($urandom_range(99) < 80);
      t = ($urandom_range(99) < 80);
      cycle(c_n, l_n, p, t, 8'($urandom), "R4/R5 random");
    end
    finish_run();
  end
endmodule